// File: doc/BRIEF.md
# Last-Value Load Predictor

This block guesses the result of a load-word instruction before memory returns it. It keeps a small direct-mapped table of entries. Each entry remembers one load's instruction address and the data that load fetched last time. A lookup presents the fetch-stage PC and gets back, in the same cycle, whether the table knows that load and, when the entry is trusted enough, a speculative 32-bit value.

When the real load data arrives, the pipeline sends the load's PC, the true value and a flag telling whether a guess was consumed. The table then updates its entry. A 2-bit saturating trust counter per entry moves up when the stored value repeats and down when it does not. The block reports a misprediction in the same cycle so the surrounding pipeline can squash dependent work. Squash and restart happen outside this block.

Top module: `ldval_predictor`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid, so `lk_hit` is 0 for every PC until an update installs an entry.
- R2: An entry is selected by PC bits [5:2], and the tag is PC bits [31:6]. `lk_hit` is 1 when the selected entry is valid and its tag equals the lookup tag. PC bits [1:0] have no effect.
- R3: `lk_pred_valid` is 1 only when `lk_hit` is 1 and the entry's counter is 2 or 3. `lk_pred_value` equals the stored value on a hit and 0 on a miss.
- R4: An update that hits and carries a value equal to the stored one raises the counter by one, holding at 3.
- R5: An update that hits with a different value lowers the counter by one, holding at 0. The stored value becomes the new value.
- R6: An update that misses (entry invalid or tag different) installs the new tag and value, marks the entry valid and sets its counter to 0.
- R7: `upd_mispredict` is combinational on the update port. It is 1 exactly when `upd_valid` and `upd_used` are both 1 and the entry either misses or holds a value different from `upd_value`.
- R8: When a lookup and an update address the same entry in one cycle, the lookup returns the state before the update. The update becomes visible from the next cycle.
- R9: Lookups never change table state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | 32 | PC of the load being looked up |
| lk_hit | output | 1 | Entry valid and tag matches |
| lk_pred_valid | output | 1 | Prediction is issued |
| lk_pred_value | output | 32 | Predicted load data |
| upd_valid | input | 1 | A load has resolved this cycle |
| upd_pc | input | 32 | PC of the resolved load |
| upd_value | input | 32 | Actual loaded data |
| upd_used | input | 1 | A prediction was consumed for this load |
| upd_mispredict | output | 1 | Consumed prediction was wrong or absent |

## Verification
Lookup results and `upd_mispredict` are due in the same cycle their inputs are applied. The bench drives inputs on the falling edge and samples one nanosecond later, before the rising edge. Table changes are due after the next rising edge, so the bench advances its own table model only after that edge and checks them through later lookups. Same-cycle lookup/update pairs are therefore compared against the model as it stood before the edge.

// File: rtl/ldval_pkg.sv
// Shared types for the last-value load predictor.
package ldval_pkg;
    // What an update does to an entry's trust counter.
    typedef enum logic [1:0] {
        CONF_HOLD  = 2'd0,
        CONF_UP    = 2'd1,
        CONF_DOWN  = 2'd2,
        CONF_CLEAR = 2'd3
    } conf_act_e;
endpackage

// File: rtl/ldval_sat.sv
// Saturating trust counter step.
// Assumes: act is CONF_HOLD when no write happens; counter width >= 1.
module ldval_sat #(
    parameter int CONF_W = 2
) (
    input  logic [CONF_W-1:0]      conf,
    input  ldval_pkg::conf_act_e   act,
    output logic [CONF_W-1:0]      conf_nxt
);
    localparam logic [CONF_W-1:0] CMAX = {CONF_W{1'b1}};

    // Next counter value, clamped at both ends.
    always_comb begin
        unique case (act)
            ldval_pkg::CONF_UP:    conf_nxt = (conf == CMAX) ? CMAX : conf + CONF_W'(1);
            ldval_pkg::CONF_DOWN:  conf_nxt = (conf == '0) ? '0 : conf - CONF_W'(1);
            ldval_pkg::CONF_CLEAR: conf_nxt = '0;
            default:               conf_nxt = conf;
        endcase
    end
endmodule

// File: rtl/ldval_entry.sv
// One table entry: valid bit, tag, last value and trust counter.
// Assumes: wr_en is high only when this entry is addressed by a resolving load.
module ldval_entry #(
    parameter int TAG_W  = 26,
    parameter int DATA_W = 32,
    parameter int CONF_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_value,
    output logic              valid,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] value,
    output logic [CONF_W-1:0] conf
);
    import ldval_pkg::*;
    localparam logic [CONF_W-1:0] CMAX = {CONF_W{1'b1}};

    conf_act_e         act;
    logic [CONF_W-1:0] conf_nxt;

    // Classify the update: hit-equal, hit-different, or replace.
    always_comb begin
        act = CONF_HOLD;
        if (wr_en) begin
            if (valid && tag == wr_tag)
                act = (value == wr_value) ? CONF_UP : CONF_DOWN;
            else
                act = CONF_CLEAR;
        end
    end

    ldval_sat #(.CONF_W(CONF_W)) u_sat (
        .conf     (conf),
        .act      (act),
        .conf_nxt (conf_nxt)
    );

    // Entry state register; every write stores the latest tag and value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            tag   <= '0;
            value <= '0;
            conf  <= '0;
        end else if (wr_en) begin
            valid <= 1'b1;
            tag   <= wr_tag;
            value <= wr_value;
            conf  <= conf_nxt;
        end
    end

    // R4: a repeat of the stored value raises trust, clamped at the top.
    a_r4_conf_up: assert property (@(posedge clk) disable iff (!rst_n)
        act == CONF_UP |=> conf == (($past(conf) == CMAX) ? CMAX : $past(conf) + CONF_W'(1)));

    // R5: a differing value lowers trust, clamped at zero, and is stored.
    a_r5_conf_down: assert property (@(posedge clk) disable iff (!rst_n)
        act == CONF_DOWN |=> (conf == (($past(conf) == '0) ? '0 : $past(conf) - CONF_W'(1)))
                             && value == $past(wr_value));

    // R6: a replacing write leaves a valid entry with zero trust.
    a_r6_replace_clears: assert property (@(posedge clk) disable iff (!rst_n)
        act == CONF_CLEAR |=> valid && conf == '0 && tag == $past(wr_tag) && value == $past(wr_value));

    // R9: no write means no state change.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid) && $stable(conf) && $stable(value));
endmodule

// File: rtl/ldval_read.sv
// Read port: selects one entry by index and compares its tag.
// Assumes: idx is below ENTRIES.
module ldval_read #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 26,
    parameter int DATA_W  = 32,
    parameter int CONF_W  = 2
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic              e_valid [ENTRIES],
    input  logic [TAG_W-1:0]  e_tag   [ENTRIES],
    input  logic [DATA_W-1:0] e_value [ENTRIES],
    input  logic [CONF_W-1:0] e_conf  [ENTRIES],
    output logic              hit,
    output logic [DATA_W-1:0] value,
    output logic [CONF_W-1:0] conf
);
    // Index mux followed by tag compare.
    always_comb begin
        hit   = 1'b0;
        value = '0;
        conf  = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (idx == IDX_W'(k)) begin
                hit   = e_valid[k] && (e_tag[k] == tag);
                value = e_value[k];
                conf  = e_conf[k];
            end
        end
    end
endmodule

// File: rtl/ldval_predictor.sv
// Last-value load predictor, direct mapped.
// Lookup and mispredict outputs are combinational on registered table state,
// so a same-cycle update is seen by lookups only from the next cycle.
// Assumes: at most one update per cycle; reset is synchronous, active low.
module ldval_predictor #(
    parameter int ENTRIES  = 16,
    parameter int PC_W     = 32,
    parameter int DATA_W   = 32,
    parameter int CONF_W   = 2,
    parameter int PRED_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_hit,
    output logic              lk_pred_valid,
    output logic [DATA_W-1:0] lk_pred_value,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic [DATA_W-1:0] upd_value,
    input  logic              upd_used,
    output logic              upd_mispredict
);
    localparam int OFS   = 2;
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - OFS;

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic              e_valid [ENTRIES];
    logic [TAG_W-1:0]  e_tag   [ENTRIES];
    logic [DATA_W-1:0] e_value [ENTRIES];
    logic [CONF_W-1:0] e_conf  [ENTRIES];
    logic              l_hit, u_hit;
    logic [DATA_W-1:0] l_value, u_value;
    logic [CONF_W-1:0] l_conf, u_conf;
    logic              unused_bits;

    // Split both PCs into index and tag; byte offset is dropped.
    assign lk_idx = lk_pc[OFS +: IDX_W];
    assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
    assign up_idx = upd_pc[OFS +: IDX_W];
    assign up_tag = upd_pc[PC_W-1 -: TAG_W];
    assign unused_bits = ^{lk_pc[OFS-1:0], upd_pc[OFS-1:0], u_conf};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        ldval_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .CONF_W(CONF_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (upd_valid && up_idx == IDX_W'(g)),
            .wr_tag   (up_tag),
            .wr_value (upd_value),
            .valid    (e_valid[g]),
            .tag      (e_tag[g]),
            .value    (e_value[g]),
            .conf     (e_conf[g])
        );
    end

    ldval_read #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
                 .DATA_W(DATA_W), .CONF_W(CONF_W)) u_lk_rd (
        .idx (lk_idx), .tag (lk_tag),
        .e_valid (e_valid), .e_tag (e_tag), .e_value (e_value), .e_conf (e_conf),
        .hit (l_hit), .value (l_value), .conf (l_conf)
    );

    ldval_read #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
                 .DATA_W(DATA_W), .CONF_W(CONF_W)) u_up_rd (
        .idx (up_idx), .tag (up_tag),
        .e_valid (e_valid), .e_tag (e_tag), .e_value (e_value), .e_conf (e_conf),
        .hit (u_hit), .value (u_value), .conf (u_conf)
    );

    // Lookup outputs: prediction gated by the trust threshold.
    always_comb begin
        lk_hit        = l_hit;
        lk_pred_valid = l_hit && (l_conf >= CONF_W'(PRED_MIN));
        lk_pred_value = l_hit ? l_value : '0;
    end

    // Flag a consumed guess that did not match the resolved data.
    always_comb begin
        upd_mispredict = upd_valid && upd_used && (!u_hit || u_value != upd_value);
    end

    // R3: a prediction never comes without a tag hit.
    a_r3_pred_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_pred_valid |-> lk_hit);

    // R3: a missing lookup returns zero data.
    a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_pred_value == '0);

    // R7: no flag unless a consumed guess is resolving.
    a_r7_flag_needs_use: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_valid && upd_used) |-> !upd_mispredict);

    // R8: state seen by a lookup does not move without an update.
    a_r8_lookup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(upd_valid) && $stable(lk_pc) |-> $stable(lk_hit) && $stable(lk_pred_value));
endmodule

// File: tb/test_ldval_predictor.sv
module test_ldval_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0, upd_pc = '0, upd_value = '0;
    logic        upd_valid = 1'b0, upd_used = 1'b0;
    logic        lk_hit, lk_pred_valid, upd_mispredict;
    logic [31:0] lk_pred_value;
    int          errors = 0, checks = 0;

    // Bench model of the table.
    bit          m_valid [16];
    logic [25:0] m_tag   [16];
    logic [31:0] m_val   [16];
    int          m_conf  [16];

    always #2 clk = ~clk;

    ldval_predictor i_ldval_predictor (
        .clk (clk), .rst_n (rst_n), .lk_pc (lk_pc), .lk_hit (lk_hit),
        .lk_pred_valid (lk_pred_valid), .lk_pred_value (lk_pred_value),
        .upd_valid (upd_valid), .upd_pc (upd_pc), .upd_value (upd_value),
        .upd_used (upd_used), .upd_mispredict (upd_mispredict)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, check before rising edge, then advance model.
    task automatic step(input string req, input logic [31:0] lpc, input logic uv,
                        input logic [31:0] upc, input logic [31:0] uval, input logic used);
        int li, ui;
        bit lh, uh;
        lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_value = uval; upd_used = used;
        #1;
        li = int'(lpc[5:2]);
        ui = int'(upc[5:2]);
        lh = m_valid[li] && m_tag[li] == lpc[31:6];
        uh = m_valid[ui] && m_tag[ui] == upc[31:6];
        chk({req, " R2 hit"}, {31'd0, lk_hit}, {31'd0, lh});
        chk({req, " R3 pred_valid"}, {31'd0, lk_pred_valid}, {31'd0, lh && m_conf[li] >= 2});
        chk({req, " R3 value"}, lk_pred_value, lh ? m_val[li] : 32'd0);
        chk({req, " R7 mispredict"}, {31'd0, upd_mispredict},
            {31'd0, uv && used && (!uh || m_val[ui] != uval)});
        @(posedge clk);
        if (uv) begin
            if (uh) begin
                if (m_val[ui] == uval) m_conf[ui] = (m_conf[ui] == 3) ? 3 : m_conf[ui] + 1;
                else                   m_conf[ui] = (m_conf[ui] == 0) ? 0 : m_conf[ui] - 1;
            end else begin
                m_valid[ui] = 1'b1;
                m_tag[ui]   = upc[31:6];
                m_conf[ui]  = 0;
            end
            m_val[ui] = uval;
        end
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 16; k++) begin
            m_valid[k] = 1'b0; m_tag[k] = '0; m_val[k] = '0; m_conf[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: after reset nothing hits, for every index and two tags.
        for (int k = 0; k < 16; k++) begin
            step("R1", {26'h0000123, k[3:0], 2'b00}, 1'b0, '0, '0, 1'b0);
            step("R1", {26'h3FFFFFF, k[3:0], 2'b11}, 1'b0, '0, '0, 1'b0);
        end

        // Directed ladder on every index.
        for (int k = 0; k < 16; k++) begin
            logic [31:0] pa = {26'h0000A5C, k[3:0], 2'b00};
            logic [31:0] pb = {26'h1234567, k[3:0], 2'b00};
            logic [31:0] va = 32'hC0DE_0000 + 32'(k);
            step("R6 install", pa, 1'b1, pa, va, 1'b0);
            for (int n = 0; n < 4; n++)
                step("R4 climb", pa, 1'b1, pa, va, n >= 2);   // R4: 0,1,2,3 then hold
            step("R4 saturate", pa | 32'd3, 1'b0, '0, '0, 1'b0); // R2: offset bits ignored
            step("R5 differ", pa, 1'b1, pa, ~va, 1'b1);
            step("R5 store new", pa, 1'b0, '0, '0, 1'b0);
            step("R8 same-cycle", pa, 1'b1, pb, va, 1'b1);
            step("R6 replaced", pa, 1'b0, '0, '0, 1'b0);
            step("R6 new tag", pb, 1'b0, '0, '0, 1'b0);
            step("R5 floor", pb, 1'b1, pb, 32'd7, 1'b0);
            step("R9 lookup only", pb, 1'b0, '0, '0, 1'b0);
        end

        // Mixed sweep over two tags and two values per index.
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] lp, up, uv;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lp = {lfsr[0] ? 26'h0000A5C : 26'h1234567, lfsr[4:1], lfsr[6:5]};
            up = {lfsr[7] ? 26'h0000A5C : 26'h1234567, lfsr[11:8], 2'b00};
            if (lfsr[12]) up[5:2] = lp[5:2];
            uv = lfsr[13] ? 32'h1111_2222 : 32'h3333_4444;
            step("R8 sweep", lp, lfsr[14] | lfsr[15], up, uv, lfsr[16]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule